// File: doc/BRIEF.md
# Receive Ring Page Pointer Manager

This block keeps track of a circular receive buffer that lives in packet memory and is carved into 256-byte pages. Two host-programmed limits define the ring: a first page and an end page. The end page itself is outside the ring. Three pointers move inside that range. The boundary pointer marks the last page the host has finished reading. The fill pointer marks the next page the receiver writes for the frame in progress. The current pointer marks where the next committed frame begins.

The receiver pulses a page strobe each time it moves to a new page. It pulses a commit strobe when a whole frame has landed, and the current pointer then takes the fill pointer's value. One page is always left unwritten. The ring is therefore full when the current pointer equals the boundary pointer, and empty when it equals the boundary pointer plus one. Both increments wrap from the last ring page back to the first. A page request made with no room left is dropped, and a sticky overflow flag is raised. That flag serves as the "receive buffer exhausted" status. Pages below the first ring page are left to the transmit side.

Top module: `rx_ring_ptr`

## Requirements
- R1: After reset the first page is 0x4C, the end page is 0x60, the boundary is 0x4C, and both the current and fill pointers are 0x4D. Empty is 1, full is 0 and overflow is 0.
- R2: A host write with select 0 loads the first page. Select 1 loads the end page, select 2 loads the boundary, and select 3 loads both the current and fill pointers. The new value appears at the outputs in the cycle after the write.
- R3: A page strobe moves the fill pointer to the next page when the fill pointer differs from the boundary.
- R4: A fill pointer sitting on the page just below the end page advances to the first page.
- R5: A commit strobe copies the fill pointer into the current pointer on the next cycle.
- R6: Empty is 1 exactly when the current pointer equals the boundary plus one. That increment wraps to the first page when the boundary is the page just below the end page.
- R7: Full is 1 exactly when the current pointer equals the boundary.
- R8: A page strobe arriving while the fill pointer equals the boundary is dropped. The fill pointer keeps its value and overflow becomes 1. Overflow stays 1 until the host clears it.
- R9: A host write with select 4 clears overflow. A host write with select 5 reloads the boundary with the first page and the current and fill pointers with the first page plus one, leaving overflow alone. Selects 6 and 7 change nothing.
- R10: When a host write and a receiver strobe act on the same register in one cycle, the host write wins. This covers a current write together with commit, a current write together with a page strobe, and an overflow clear together with a dropped page strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 3 | Host write target / command select |
| host_wdata | input | PAGE_W | Host write data (page number) |
| page_adv | input | 1 | Receiver moved to a new page |
| frame_commit | input | 1 | Receiver committed a complete frame |
| start_page | output | PAGE_W | First ring page |
| stop_page | output | PAGE_W | End page (outside the ring) |
| bnd_page | output | PAGE_W | Boundary pointer |
| cur_page | output | PAGE_W | Current pointer |
| fill_page | output | PAGE_W | Fill pointer |
| ring_empty | output | 1 | Ring holds no unread page |
| ring_full | output | 1 | Ring has no free page |
| ring_overflow | output | 1 | Sticky: a page request was dropped |

## Verification
The assertions do not assume the pointers stay inside the ring, because the host may write any page value. They do assume a host write to the current pointer and a receiver strobe are the only sources of change for the fill and current registers. The stimulus programs a short four-page ring, so that wrap, full and dropped requests all occur within a few cycles. Every host-written pointer is a page inside that ring. Collisions between host writes and receiver strobes are driven on purpose, one cycle at a time, so each priority case is seen on its own.

// File: rtl/rrp_pkg.sv
package rrp_pkg;

   typedef enum logic [2:0] {
      SEL_FIRST   = 3'd0,
      SEL_END     = 3'd1,
      SEL_BND     = 3'd2,
      SEL_CUR     = 3'd3,
      SEL_CLR_OVF = 3'd4,
      SEL_REINIT  = 3'd5
   } host_sel_e;

   localparam int unsigned NUM_WRAP = 3;
   localparam int unsigned WRAP_FILL = 0;
   localparam int unsigned WRAP_BND = 1;
   localparam int unsigned WRAP_FIRST = 2;

endpackage

// File: rtl/rrp_page_wrap.sv
module rrp_page_wrap #(
   parameter int unsigned PAGE_W = 8
) (
   input  logic [PAGE_W-1:0] page_in,
   input  logic [PAGE_W-1:0] first_pg,
   input  logic [PAGE_W-1:0] end_pg,
   output logic [PAGE_W-1:0] page_nxt
);

   logic [PAGE_W-1:0] inc;

   always_comb begin
      inc = page_in + 1'b1;
      page_nxt = (inc == end_pg) ? first_pg : inc;
   end

endmodule

// File: rtl/rrp_bounds_regs.sv
module rrp_bounds_regs #(
   parameter int unsigned PAGE_W = 8,
   parameter logic [PAGE_W-1:0] RST_FIRST = 8'h4C,
   parameter logic [PAGE_W-1:0] RST_END = 8'h60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_first,
   input  logic              wr_end,
   input  logic [PAGE_W-1:0] wdata,
   output logic [PAGE_W-1:0] first_pg,
   output logic [PAGE_W-1:0] end_pg
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         first_pg <= RST_FIRST;
         end_pg <= RST_END;
      end else begin
         if (wr_first) first_pg <= wdata;
         if (wr_end) end_pg <= wdata;
      end
   end

   a_r2_first_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_first |=> first_pg == $past(wdata));
   a_r2_end_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_end |=> end_pg == $past(wdata));

endmodule

// File: rtl/rrp_ring_ptrs.sv
module rrp_ring_ptrs #(
   parameter int unsigned PAGE_W = 8,
   parameter logic [PAGE_W-1:0] RST_BND = 8'h4C,
   parameter logic [PAGE_W-1:0] RST_CUR = 8'h4D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_bnd,
   input  logic              wr_cur,
   input  logic              clr_ovf,
   input  logic              reinit,
   input  logic [PAGE_W-1:0] wdata,
   input  logic [PAGE_W-1:0] first_pg,
   input  logic [PAGE_W-1:0] first_nxt,
   input  logic [PAGE_W-1:0] fill_nxt,
   input  logic              page_adv,
   input  logic              frame_commit,
   output logic [PAGE_W-1:0] bnd_pg,
   output logic [PAGE_W-1:0] cur_pg,
   output logic [PAGE_W-1:0] fill_pg,
   output logic              ovf
);

   logic no_room;
   logic adv_ok;
   logic adv_drop;

   always_comb begin
      no_room = (fill_pg == bnd_pg);
      adv_ok = page_adv && !no_room;
      adv_drop = page_adv && no_room;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bnd_pg <= RST_BND;
         cur_pg <= RST_CUR;
         fill_pg <= RST_CUR;
         ovf <= 1'b0;
      end else begin
         // boundary: host only
         if (reinit) bnd_pg <= first_pg;
         else if (wr_bnd) bnd_pg <= wdata;

         // current: host wins over commit
         if (reinit) cur_pg <= first_nxt;
         else if (wr_cur) cur_pg <= wdata;
         else if (frame_commit) cur_pg <= fill_pg;

         // fill: host wins over page strobe
         if (reinit) fill_pg <= first_nxt;
         else if (wr_cur) fill_pg <= wdata;
         else if (adv_ok) fill_pg <= fill_nxt;

         // overflow: host clear wins over a dropped request
         if (clr_ovf) ovf <= 1'b0;
         else if (adv_drop) ovf <= 1'b1;
      end
   end

   a_r3_fill_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (page_adv && !wr_cur && !reinit && fill_pg != bnd_pg && fill_nxt != fill_pg)
      |=> fill_pg != $past(fill_pg));
   a_r8_drop_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (page_adv && !wr_cur && !reinit && fill_pg == bnd_pg) |=> $stable(fill_pg));
   a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr_ovf) |=> ovf);
   a_r5_commit_copy: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_commit && !wr_cur && !reinit) |=> cur_pg == $past(fill_pg));
   a_r10_host_cur_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cur && !reinit) |=> (cur_pg == $past(wdata)) && (fill_pg == $past(wdata)));
   a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ovf |=> !ovf);

endmodule

// File: rtl/rx_ring_ptr.sv
module rx_ring_ptr #(
   parameter int unsigned PAGE_W = 8,
   parameter logic [PAGE_W-1:0] RST_FIRST = 8'h4C,
   parameter logic [PAGE_W-1:0] RST_END = 8'h60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [2:0]        host_sel,
   input  logic [PAGE_W-1:0] host_wdata,
   input  logic              page_adv,
   input  logic              frame_commit,
   output logic [PAGE_W-1:0] start_page,
   output logic [PAGE_W-1:0] stop_page,
   output logic [PAGE_W-1:0] bnd_page,
   output logic [PAGE_W-1:0] cur_page,
   output logic [PAGE_W-1:0] fill_page,
   output logic              ring_empty,
   output logic              ring_full,
   output logic              ring_overflow
);
   import rrp_pkg::*;

   localparam logic [PAGE_W-1:0] RST_CUR = RST_FIRST + 1'b1;

   initial begin
      assert (PAGE_W >= 2)
         else $error("PAGE_W must be at least 2");
      assert (RST_END > RST_CUR)
         else $error("reset ring must hold at least two pages");
   end

   logic wr_first, wr_end, wr_bnd, wr_cur, clr_ovf, reinit;
   logic [PAGE_W-1:0] wrap_in  [NUM_WRAP];
   logic [PAGE_W-1:0] wrap_out [NUM_WRAP];

   always_comb begin
      wr_first = host_we && (host_sel == SEL_FIRST);
      wr_end   = host_we && (host_sel == SEL_END);
      wr_bnd   = host_we && (host_sel == SEL_BND);
      wr_cur   = host_we && (host_sel == SEL_CUR);
      clr_ovf  = host_we && (host_sel == SEL_CLR_OVF);
      reinit   = host_we && (host_sel == SEL_REINIT);
      wrap_in[WRAP_FILL]  = fill_page;
      wrap_in[WRAP_BND]   = bnd_page;
      wrap_in[WRAP_FIRST] = start_page;
   end

   for (genvar g = 0; g < NUM_WRAP; g++) begin : g_wrap
      rrp_page_wrap #(.PAGE_W(PAGE_W)) u_wrap (
         .page_in  (wrap_in[g]),
         .first_pg (start_page),
         .end_pg   (stop_page),
         .page_nxt (wrap_out[g])
      );
   end

   rrp_bounds_regs #(
      .PAGE_W(PAGE_W), .RST_FIRST(RST_FIRST), .RST_END(RST_END)
   ) u_bounds (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_first (wr_first),
      .wr_end   (wr_end),
      .wdata    (host_wdata),
      .first_pg (start_page),
      .end_pg   (stop_page)
   );

   rrp_ring_ptrs #(
      .PAGE_W(PAGE_W), .RST_BND(RST_FIRST), .RST_CUR(RST_CUR)
   ) u_ptrs (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_bnd       (wr_bnd),
      .wr_cur       (wr_cur),
      .clr_ovf      (clr_ovf),
      .reinit       (reinit),
      .wdata        (host_wdata),
      .first_pg     (start_page),
      .first_nxt    (wrap_out[WRAP_FIRST]),
      .fill_nxt     (wrap_out[WRAP_FILL]),
      .page_adv     (page_adv),
      .frame_commit (frame_commit),
      .bnd_pg       (bnd_page),
      .cur_pg       (cur_page),
      .fill_pg      (fill_page),
      .ovf          (ring_overflow)
   );

   always_comb begin
      ring_full  = (cur_page == bnd_page);
      ring_empty = (cur_page == wrap_out[WRAP_BND]);
   end

   a_r6_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_out[WRAP_BND] != bnd_page) |-> !(ring_empty && ring_full));
   a_r9_reinit_load: assert property (@(posedge clk) disable iff (!rst_n)
      reinit |=> bnd_page == $past(start_page));

endmodule

// File: tb/rx_ring_ptr_bench.sv
module rx_ring_ptr_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_we = 1'b0;
   logic [2:0] host_sel = 3'd0;
   logic [7:0] host_wdata = 8'd0;
   logic       page_adv = 1'b0;
   logic       frame_commit = 1'b0;
   logic [7:0] start_page, stop_page, bnd_page, cur_page, fill_page;
   logic       ring_empty, ring_full, ring_overflow;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rx_ring_ptr u_rx_ring_ptr (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
      .host_wdata(host_wdata), .page_adv(page_adv), .frame_commit(frame_commit),
      .start_page(start_page), .stop_page(stop_page), .bnd_page(bnd_page),
      .cur_page(cur_page), .fill_page(fill_page), .ring_empty(ring_empty),
      .ring_full(ring_full), .ring_overflow(ring_overflow)
   );

   typedef struct packed {
      logic       we;
      logic [2:0] sel;
      logic [7:0] wd;
      logic       adv;
      logic       cmt;
      logic [7:0] e_cur;
      logic [7:0] e_bnd;
      logic [7:0] e_fill;
      logic       e_empty;
      logic       e_full;
      logic       e_ovf;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t TBL [NV] = '{
      '{1'b1, 3'd1, 8'h50, 1'b0, 1'b0, 8'h4D, 8'h4C, 8'h4D, 1'b1, 1'b0, 1'b0},
      '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 8'h4D, 8'h4C, 8'h4E, 1'b1, 1'b0, 1'b0},
      '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 8'h4D, 8'h4C, 8'h4F, 1'b1, 1'b0, 1'b0},
      '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 8'h4D, 8'h4C, 8'h4C, 1'b1, 1'b0, 1'b0},
      '{1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 8'h4C, 8'h4C, 8'h4C, 1'b0, 1'b1, 1'b0},
      '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 8'h4C, 8'h4C, 8'h4C, 1'b0, 1'b1, 1'b1},
      '{1'b1, 3'd2, 8'h4E, 1'b0, 1'b0, 8'h4C, 8'h4E, 8'h4C, 1'b0, 1'b0, 1'b1},
      '{1'b1, 3'd4, 8'h00, 1'b0, 1'b0, 8'h4C, 8'h4E, 8'h4C, 1'b0, 1'b0, 1'b0},
      '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 8'h4C, 8'h4E, 8'h4D, 1'b0, 1'b0, 1'b0},
      '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 8'h4C, 8'h4E, 8'h4E, 1'b0, 1'b0, 1'b0},
      '{1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 8'h4C, 8'h4E, 8'h4E, 1'b0, 1'b0, 1'b1},
      '{1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 8'h4E, 8'h4E, 8'h4E, 1'b0, 1'b1, 1'b1},
      '{1'b1, 3'd2, 8'h4F, 1'b0, 1'b0, 8'h4E, 8'h4F, 8'h4E, 1'b0, 1'b0, 1'b1},
      '{1'b1, 3'd2, 8'h4D, 1'b0, 1'b0, 8'h4E, 8'h4D, 8'h4E, 1'b1, 1'b0, 1'b1},
      '{1'b1, 3'd3, 8'h4C, 1'b0, 1'b1, 8'h4C, 8'h4D, 8'h4C, 1'b0, 1'b0, 1'b1},
      '{1'b1, 3'd2, 8'h4F, 1'b0, 1'b0, 8'h4C, 8'h4F, 8'h4C, 1'b1, 1'b0, 1'b1},
      '{1'b1, 3'd2, 8'h4C, 1'b0, 1'b0, 8'h4C, 8'h4C, 8'h4C, 1'b0, 1'b1, 1'b1},
      '{1'b1, 3'd4, 8'h00, 1'b1, 1'b0, 8'h4C, 8'h4C, 8'h4C, 1'b0, 1'b1, 1'b0},
      '{1'b1, 3'd6, 8'h55, 1'b0, 1'b0, 8'h4C, 8'h4C, 8'h4C, 1'b0, 1'b1, 1'b0},
      '{1'b1, 3'd5, 8'h00, 1'b0, 1'b0, 8'h4D, 8'h4C, 8'h4D, 1'b1, 1'b0, 1'b0},
      '{1'b1, 3'd3, 8'h4F, 1'b1, 1'b0, 8'h4F, 8'h4C, 8'h4F, 1'b0, 1'b0, 1'b0}
   };

   function automatic string row_req(int i);
      case (i)
         0:  return "R2 end write";
         1, 2, 8, 9: return "R3 fill advance";
         3:  return "R4 fill wrap";
         4, 11: return "R5/R7 commit to full";
         5, 10: return "R8 dropped request";
         6, 12: return "R2/R7 boundary write";
         7:  return "R9 overflow clear";
         13: return "R6 empty";
         14: return "R10 cur write over commit";
         15: return "R6 empty wrap";
         16: return "R7 full";
         17: return "R10 clear over drop";
         18: return "R9 unused select";
         19: return "R9 reinit";
         default: return "R10 cur write over page strobe";
      endcase
   endfunction

   task automatic check(string req, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic check_reset_state(string tag);
      check({tag, " R1 first"}, start_page, 8'h4C);
      check({tag, " R1 end"}, stop_page, 8'h60);
      check({tag, " R1 bnd"}, bnd_page, 8'h4C);
      check({tag, " R1 cur"}, cur_page, 8'h4D);
      check({tag, " R1 fill"}, fill_page, 8'h4D);
      check({tag, " R1 empty"}, ring_empty, 1);
      check({tag, " R1 full"}, ring_full, 0);
      check({tag, " R1 ovf"}, ring_overflow, 0);
   endtask

   task automatic host(input logic [2:0] s, input logic [7:0] d);
      @(negedge clk);
      host_we = 1'b1; host_sel = s; host_wdata = d;
      @(posedge clk); #5;
      host_we = 1'b0;
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #5;
      check_reset_state("start");
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         host_we = TBL[i].we; host_sel = TBL[i].sel; host_wdata = TBL[i].wd;
         page_adv = TBL[i].adv; frame_commit = TBL[i].cmt;
         @(posedge clk); #5;
         host_we = 1'b0; page_adv = 1'b0; frame_commit = 1'b0;
         check({row_req(i), " cur"}, cur_page, TBL[i].e_cur);
         check({row_req(i), " bnd"}, bnd_page, TBL[i].e_bnd);
         check({row_req(i), " fill"}, fill_page, TBL[i].e_fill);
         check({row_req(i), " empty"}, ring_empty, TBL[i].e_empty);
         check({row_req(i), " full"}, ring_full, TBL[i].e_full);
         check({row_req(i), " ovf"}, ring_overflow, TBL[i].e_ovf);
      end
      check("R2 end page readback", stop_page, 8'h50);
      check("R9 select 6 leaves first page", start_page, 8'h4C);

      // R2: first page write, then R9 reinit uses it
      host(3'd0, 8'h48);
      check("R2 first page write", start_page, 8'h48);
      host(3'd5, 8'h00);
      check("R9 reinit bnd", bnd_page, 8'h48);
      check("R9 reinit cur", cur_page, 8'h49);
      check("R6 empty after reinit", ring_empty, 1);

      // R9: select 7 changes nothing
      host(3'd7, 8'h33);
      check("R9 select 7 cur", cur_page, 8'h49);
      check("R9 select 7 bnd", bnd_page, 8'h48);
      check("R9 select 7 first", start_page, 8'h48);
      check("R9 select 7 end", stop_page, 8'h50);

      // R8: overflow stays until cleared
      host(3'd2, 8'h49);
      @(negedge clk); page_adv = 1'b1;
      @(posedge clk); #5; page_adv = 1'b0;
      check("R8 drop sets ovf", ring_overflow, 1);
      repeat (4) @(posedge clk);
      #5;
      check("R8 ovf sticky", ring_overflow, 1);
      check("R8 fill held", fill_page, 8'h49);

      // R1: reset mid-run
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk); #5;
      check_reset_state("midrun");
      @(negedge clk); rst_n = 1'b1;

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule